// File: doc/BRIEF.md
# Network Controller Status Register

This block is the main control and status word of an Ethernet-style controller. A host reads it combinationally and writes it through a simple synchronous port. The register collects the controller's engine events as sticky flags: memory error, receive done, transmit done and initialization done. It summarises these flags, together with two externally held error flags, into one read-only interrupt flag. When the host has enabled interrupts, that summary drives an active-low interrupt pin.

The register also tracks whether the receiver and transmitter are running. A start command switches them on, provided initialization has completed and the mode bits loaded at initialization do not disable them. Bus errors, transmit faults and a disabling mode at init-done switch them off again. A stop command returns nearly all of the register to its reset state.

Bits 15:12 and 3:0 belong to neighbouring logic. They are passed through on reads, and host writes to them are ignored.

Top module: `netctl_csr`

## Requirements
- R1: After reset, bits 11:4 read as zero and `irq_n` is 1. The read word is laid out as {ext_hi[3:0], merr, rx_int, tx_int, init_done, intr, int_en, rx_on, tx_on, ext_lo[3:0]}, most significant bit first.
- R2: A one-cycle pulse on `ev_merr`, `ev_rx_done`, `ev_tx_done` or `ev_init_done` sets bit 11, 10, 9 or 8 respectively on the next clock. A host write with a 1 in one of these bit positions clears that flag. A write with a 0 in that position leaves the flag unchanged.
- R3: When an event pulse and a host write-1 clear reach the same flag in the same cycle, the flag is 1 afterwards.
- R4: Bit 7 (intr) equals the OR of bits 11:8, `ext_hi[2]` (babble) and `ext_hi[0]` (missed frame). Host writes to bit 7 have no effect.
- R5: `irq_n` is registered. It is 0 one clock after a cycle in which bit 6 and bit 7 are both 1, and 1 one clock after any other cycle.
- R6: A `cmd_stop` pulse clears bits 11:8, bit 6, bit 5, bit 4 and the record that initialization has completed. Stop takes precedence over every other input in the same cycle.
- R7: Bit 6 (int_en) takes the value of `wr_data[6]` on every host write that does not coincide with a stop, including writes made while the controller is stopped.
- R8: An `ev_merr` pulse clears both bit 5 and bit 4 in the same update that sets bit 11.
- R9: A `cmd_start` pulse sets bit 5 if initialization has completed since the last stop or reset and `mode_drx` is 0. It sets bit 4 under the same condition if `mode_dtx` is 0. It sets neither bit if initialization has not completed.
- R10: `ev_init_done` with `mode_drx` = 1 clears bit 5, and with `mode_dtx` = 1 clears bit 4. `ev_tx_fault` clears bit 4. Each of these clears takes precedence over a start in the same cycle.
- R11: Bits 15:12 read `ext_hi` and bits 3:0 read `ext_lo` unchanged. Host writes cannot alter them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Host write strobe |
| wr_data | input | 16 | Host write data |
| rd_data | output | 16 | Combinational read data |
| ext_hi | input | 4 | Externally held bits 15:12 (bit 2 babble, bit 0 missed frame) |
| ext_lo | input | 4 | Externally held bits 3:0 |
| cmd_stop | input | 1 | Stop command pulse |
| cmd_start | input | 1 | Start command pulse |
| ev_merr | input | 1 | Bus memory error event |
| ev_rx_done | input | 1 | Receive descriptor update event |
| ev_tx_done | input | 1 | Transmit descriptor update event |
| ev_init_done | input | 1 | Initialization complete event |
| ev_tx_fault | input | 1 | Transmit underflow or buffer error event |
| mode_drx | input | 1 | Receiver disabled by mode |
| mode_dtx | input | 1 | Transmitter disabled by mode |
| irq_n | output | 1 | Registered active-low interrupt pin |

## Verification
Every cycle, the assertions check the following. A stop empties the flags. A memory error or transmit fault leaves the on-bits cleared. An event racing a clear still leaves its flag set. The pin follows the enable-and-summary pair one clock later. Only the bench's scenarios show the conditional behaviour of start, because it depends on initialization history and the mode bits. They also show that the external bits and the summary bit ignore host writes, and that enable can be rewritten after a stop.

// File: rtl/netctl_csr.sv
module netctl_csr #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] rd_data,
  input  logic [3:0]   ext_hi,
  input  logic [3:0]   ext_lo,
  input  logic         cmd_stop,
  input  logic         cmd_start,
  input  logic         ev_merr,
  input  logic         ev_rx_done,
  input  logic         ev_tx_done,
  input  logic         ev_init_done,
  input  logic         ev_tx_fault,
  input  logic         mode_drx,
  input  logic         mode_dtx,
  output logic         irq_n
);
  localparam int B_MERR = 11;
  localparam int B_RINT = 10;
  localparam int B_TINT = 9;
  localparam int B_IDON = 8;
  localparam int B_INEA = 6;

  logic merr, rint, tint, idon, inea, rx_on, tx_on, inited, intr;
  logic [3:0] clr;

  assign clr  = wr_en ? wr_data[B_MERR:B_IDON] : 4'b0;
  assign intr = merr | rint | tint | idon | ext_hi[2] | ext_hi[0];
  assign rd_data = {ext_hi, merr, rint, tint, idon, intr, inea, rx_on, tx_on, ext_lo};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      merr <= 1'b0; rint <= 1'b0; tint <= 1'b0; idon <= 1'b0;
      inea <= 1'b0; rx_on <= 1'b0; tx_on <= 1'b0; inited <= 1'b0;
    end else if (cmd_stop) begin
      merr <= 1'b0; rint <= 1'b0; tint <= 1'b0; idon <= 1'b0;
      inea <= 1'b0; rx_on <= 1'b0; tx_on <= 1'b0; inited <= 1'b0;
    end else begin
      merr <= (merr & ~clr[3]) | ev_merr;
      rint <= (rint & ~clr[2]) | ev_rx_done;
      tint <= (tint & ~clr[1]) | ev_tx_done;
      idon <= (idon & ~clr[0]) | ev_init_done;
      if (wr_en) inea <= wr_data[B_INEA];
      if (ev_init_done) inited <= 1'b1;
      if (ev_merr || (ev_init_done && mode_drx)) rx_on <= 1'b0;
      else if (cmd_start && inited && !mode_drx) rx_on <= 1'b1;
      if (ev_merr || ev_tx_fault || (ev_init_done && mode_dtx)) tx_on <= 1'b0;
      else if (cmd_start && inited && !mode_dtx) tx_on <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_n <= 1'b1;
    else        irq_n <= ~(inea & intr);
  end

  assert_merr_halts_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ev_merr |=> (!rd_data[5] && !rd_data[4]));
  assert_fault_halts_tx_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ev_tx_fault |=> !rd_data[4]);
  assert_stop_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_stop |=> (rd_data[11:8] == 4'b0 && !rd_data[6] && !rd_data[5] && !rd_data[4]));
  assert_set_beats_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_rx_done && !cmd_stop) |=> rd_data[B_RINT]);
  assert_irq_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[6] && rd_data[7]) |=> !irq_n);
  assert_irq_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_data[6] && rd_data[7]) |=> irq_n);
endmodule

// File: tb/netctl_csr_test.sv
module netctl_csr_test;
  localparam int PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [15:0] wr_data = '0, rd_data;
  logic [3:0] ext_hi = '0, ext_lo = '0;
  logic cmd_stop = 0, cmd_start = 0, ev_merr = 0, ev_rx_done = 0, ev_tx_done = 0;
  logic ev_init_done = 0, ev_tx_fault = 0, mode_drx = 0, mode_dtx = 0;
  logic irq_n;

  int checks = 0, errors = 0;
  logic m_merr, m_rint, m_tint, m_idon, m_inea, m_rx, m_tx, m_init, m_irqn;

  always #(PERIOD/2) clk = ~clk;

  netctl_csr uut (.*);

  function automatic logic m_intr();
    return m_merr | m_rint | m_tint | m_idon | ext_hi[2] | ext_hi[0];
  endfunction

  function automatic logic [15:0] exp_rd();
    return {ext_hi, m_merr, m_rint, m_tint, m_idon, m_intr(), m_inea, m_rx, m_tx, ext_lo};
  endfunction

  task automatic model_reset();
    m_merr = 0; m_rint = 0; m_tint = 0; m_idon = 0;
    m_inea = 0; m_rx = 0; m_tx = 0; m_init = 0; m_irqn = 1;
  endtask

  task automatic check(input string tag);
    checks++;
    if (rd_data !== exp_rd()) begin
      errors++;
      $display("FAIL %s rd_data actual %h expected %h", tag, rd_data, exp_rd());
    end
    checks++;
    if (irq_n !== m_irqn) begin
      errors++;
      $display("FAIL %s irq_n actual %b expected %b", tag, irq_n, m_irqn);
    end
  endtask

  task automatic step(input string tag);
    logic [3:0] c;
    logic n_irqn;
    @(negedge clk);
    n_irqn = ~(m_inea & m_intr());
    c = wr_en ? wr_data[11:8] : 4'b0;
    if (cmd_stop) begin
      m_merr = 0; m_rint = 0; m_tint = 0; m_idon = 0;
      m_inea = 0; m_rx = 0; m_tx = 0; m_init = 0;
    end else begin
      m_merr = (m_merr & ~c[3]) | ev_merr;
      m_rint = (m_rint & ~c[2]) | ev_rx_done;
      m_tint = (m_tint & ~c[1]) | ev_tx_done;
      m_idon = (m_idon & ~c[0]) | ev_init_done;
      if (wr_en) m_inea = wr_data[6];
      if (ev_merr || (ev_init_done && mode_drx)) m_rx = 0;
      else if (cmd_start && m_init && !mode_drx) m_rx = 1;
      if (ev_merr || ev_tx_fault || (ev_init_done && mode_dtx)) m_tx = 0;
      else if (cmd_start && m_init && !mode_dtx) m_tx = 1;
      if (ev_init_done) m_init = 1;
    end
    m_irqn = n_irqn;
    @(posedge clk);
    #1;
    check(tag);
    wr_en = 0; cmd_stop = 0; cmd_start = 0; ev_merr = 0; ev_rx_done = 0;
    ev_tx_done = 0; ev_init_done = 0; ev_tx_fault = 0;
  endtask

  task automatic hwrite(input logic [15:0] d);
    wr_en = 1; wr_data = d;
  endtask

  initial begin
    #(PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    model_reset();
    ext_lo = 4'h5;
    repeat (3) @(posedge clk);
    #1;
    check("R1 R11 reset state");
    @(negedge clk); rst_n = 1;

    ev_init_done = 1;                      step("R2 init done sets bit 8, R4 summary");
    hwrite(16'h0000);                      step("R2 write 0 keeps flag");
    hwrite(16'h0080);                      step("R4 write to bit 7 ignored");
    hwrite(16'h0040);                      step("R7 enable written");
                                           step("R5 pin low after enable");
    cmd_start = 1;                         step("R9 start turns both on");
    ev_tx_fault = 1;                       step("R10 tx fault clears tx_on");
    ev_merr = 1; hwrite(16'h0040);         step("R8 memory error halts both");
    ev_rx_done = 1; hwrite(16'h0440);      step("R3 set beats clear");
    hwrite(16'h0840);                      step("R2 write 1 clears merr");
    cmd_stop = 1; hwrite(16'h0040);        step("R6 stop clears all");
    hwrite(16'h0040);                      step("R7 enable set while stopped");
    cmd_start = 1;                         step("R9 start before init ignored");
    mode_drx = 1; ev_init_done = 1;        step("R10 init done with rx disabled");
    cmd_start = 1;                         step("R9 start honours rx disable");
    mode_dtx = 1; ev_init_done = 1;        step("R10 init done with tx disabled");
    mode_drx = 0; mode_dtx = 0;
    cmd_stop = 1;                          step("R6 stop again");
    ext_hi = 4'b0100;                      step("R4 babble drives summary");
    hwrite(16'h0040);                      step("R5 enable with babble");
                                           step("R5 pin low from babble");
    ext_hi = 4'b0001;                      step("R4 missed frame drives summary");
    hwrite(16'hF00F);                      step("R11 writes to external bits ignored");
    ext_hi = 4'hA; ext_lo = 4'h3;          step("R11 external bits pass through");

    for (int i = 0; i < 3000; i++) begin
      wr_en = ($urandom % 4) == 0;
      wr_data = 16'($urandom);
      cmd_stop = ($urandom % 40) == 0;
      cmd_start = ($urandom % 6) == 0;
      ev_merr = ($urandom % 25) == 0;
      ev_rx_done = ($urandom % 5) == 0;
      ev_tx_done = ($urandom % 5) == 0;
      ev_init_done = ($urandom % 12) == 0;
      ev_tx_fault = ($urandom % 20) == 0;
      mode_drx = ($urandom % 4) == 0;
      mode_dtx = ($urandom % 4) == 0;
      ext_hi = 4'($urandom);
      ext_lo = 4'($urandom);
      step("R2 R3 R4 R5 R6 R7 R8 R9 R10 R11 random");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule